// File: doc/BRIEF.md
# Tau-adic Expander and Double-Base Block Recoder

This block turns a reduced scalar of a binary anomalous curve, given as a pair of signed integers (r0, r1) that stands for r0 + r1·τ in the ring Z[τ], into a short list of signed double-base terms ±τ^a(τ−1)^b. It first peels off the unsigned τ-adic digits one per cycle. It does this by testing the parity of r0, removing a set digit, and dividing the pair by τ. The Frobenius root τ satisfies τ² = μτ − 2, and the sign μ is a build parameter.

The digit string is gathered into groups of `W` digits, counted from digit 0. Each finished group is used as the address of a small table that holds the minimal (τ, τ−1) expansion of every possible group value. The table's terms are streamed out with their τ exponent raised by `W` times the group index.

A start/busy/done handshake frames one conversion. Terms leave on a valid/ready stream. The running count of emitted terms and the largest (τ−1) exponent seen are presented on ports, so that a downstream point-multiplication sequencer can size its row loop. The table is filled through a plain write port while the block is idle.

Top module: `tau_block_recoder`

## Requirements
- R1: After reset, busy, done and termValid are 0, and termTotal and maxB are 0.
- R2: A start pulse while idle captures pairR0/pairR1 (two's complement) and raises busy in the next cycle. A start pulse while busy is ignored, and the running conversion keeps its captured pair.
- R3: Each step takes digit 1 when r0 is odd and digit 0 otherwise. It subtracts the digit from r0 and replaces (r0, r1) with (r1 + μ·r0/2, −r0/2). Stepping stops when both halves are zero. The internal registers never overflow for any IN_W-bit input.
- R4: The digit string is cut into groups of W digits, starting at digit 0. Digit j of group k is bit j of the table address. Every term taken from group k carries termA = k·W plus the table's local exponent.
- R5: A group whose value is zero emits no term. An all-zero input completes with no terms at all.
- R6: Terms come out with lower groups first, and within one group in table slot order 0, 1, 2, and so on.
- R7: A term is offered with termValid high and is taken at a rising edge where termReady is high. While it is not taken, termValid stays high and termNeg/termA/termB stay unchanged.
- R8: termTotal equals the number of terms taken since the last accepted start. maxB equals the largest termB among those terms. Both are cleared by an accepted start.
- R9: done is high for exactly one cycle, after the last term of a conversion has been taken. busy is low in that cycle and afterwards.
- R10: With μ = +1 and W = 7, input (−104, 50) yields digits at positions 2, 5, 9, 11, 12 and 13. Given table entries 36 → {+τ²(τ−1)²} and 116 → {+τ(τ−1), +τ(τ−1)⁶}, the output is exactly (+,2,2), (+,8,1), (+,8,6), with termTotal = 3 and maxB = 6.
- R11: A table entry is written with tblWe at address tblAddr. Slot s occupies bits [s·TW +: TW], where TW = 1 + LA_W + B_W, and holds {neg, localA, b} from MSB to LSB. The term count sits in the top CNT_W bits, and a count above MAXT is treated as MAXT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (honoured only when idle) |
| pairR0 | input | IN_W | Rational part r0, two's complement |
| pairR1 | input | IN_W | τ part r1, two's complement |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| termValid | output | 1 | A term is offered |
| termReady | input | 1 | Consumer takes the offered term |
| termNeg | output | 1 | Term sign, 1 = negative |
| termA | output | A_W | τ exponent of the term |
| termB | output | B_W | (τ−1) exponent of the term |
| maxB | output | B_W | Largest (τ−1) exponent emitted so far |
| termTotal | output | D_W | Number of terms emitted so far |
| tblWe | input | 1 | Table write enable |
| tblAddr | input | W | Table write address (group value) |
| tblData | input | ENT_W | Table entry to write |

## Verification
The step that writes the last digit of a group can be the same step that drives the remainder to zero. When that happens, the final full group is handed to the lookup and stepping finishes together. The example input (−104, 50) provokes this, because its fourteen digits fill exactly two groups of seven. The τ⁹ input (6, −17) adds a leading empty group ahead of the last one. Each run is judged against a term list that the bench derives from its own digit model and its copy of the table. A missing, duplicated or empty trailing group would change the list, termTotal or the done timing.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXPAND,
    ST_EMIT,
    ST_FIN
  } tbrState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic load;      // capture pair, clear group, index and statistics
    logic step;      // one division by tau, digit into the group
    logic flushGrp;  // group finished: clear it, advance the group index
    logic takeTerm;  // offered term accepted
  } tbrCtl_s;

endpackage

// File: rtl/tbr_ctrl.sv
module tbr_ctrl
  import tbr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    termReady,
  input  logic    pairZero,
  input  logic    posLast,
  input  logic    grpNonzero,
  input  logic    entryEmpty,
  input  logic    lastTerm,
  output tbrCtl_s ctl,
  output logic    busy,
  output logic    done,
  output logic    termValid
);

  tbrState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    ctl       = '0;
    termValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateD   = ST_EXPAND;
        end
      end
      ST_EXPAND: begin
        if (pairZero) begin
          stateD = grpNonzero ? ST_EMIT : ST_FIN;
        end else begin
          ctl.step = 1'b1;
          if (posLast) stateD = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (entryEmpty) begin
          ctl.flushGrp = 1'b1;
          stateD       = ST_EXPAND;
        end else begin
          termValid = 1'b1;
          if (termReady) begin
            ctl.takeTerm = 1'b1;
            if (lastTerm) begin
              ctl.flushGrp = 1'b1;
              stateD       = ST_EXPAND;
            end
          end
        end
      end
      ST_FIN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ == ST_EXPAND) || (stateQ == ST_EMIT);
  assign done = (stateQ == ST_FIN);

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    termValid && !termReady |=> termValid); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !termValid); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |-> !ctl.load); // R2

endmodule

// File: rtl/tbr_datapath.sv
module tbr_datapath
  import tbr_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int W     = 7,
  parameter int MAXT  = 4,
  parameter int LA_W  = 4,
  parameter int B_W   = 4,
  parameter int A_W   = 8,
  parameter int D_W   = 8,
  parameter int MU    = 1,
  localparam int TW    = 1 + LA_W + B_W,
  localparam int CNT_W = $clog2(MAXT + 1),
  localparam int ENT_W = CNT_W + MAXT * TW
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbrCtl_s          ctl,
  input  logic [IN_W-1:0]  pairR0,
  input  logic [IN_W-1:0]  pairR1,
  input  logic             tblWe,
  input  logic [W-1:0]     tblAddr,
  input  logic [ENT_W-1:0] tblData,
  output logic             pairZero,
  output logic             posLast,
  output logic             grpNonzero,
  output logic             entryEmpty,
  output logic             lastTerm,
  output logic             termNeg,
  output logic [A_W-1:0]   termA,
  output logic [B_W-1:0]   termB,
  output logic [B_W-1:0]   maxB,
  output logic [D_W-1:0]   termTotal
);

  localparam int R_W   = IN_W + 3;
  localparam int POS_W = $clog2(W + 1);
  localparam int TBL_N = 1 << W;

  // remainder pair
  logic signed [R_W-1:0] r0Q, r1Q, digitS, r0Even, halfV, u0, u1;
  logic                  digit;

  assign digit  = r0Q[0];
  assign digitS = {{(R_W-1){1'b0}}, digit};
  assign r0Even = r0Q - digitS;
  assign halfV  = r0Even >>> 1;

  generate
    if (MU > 0) begin : g_muPos
      assign u0 = r1Q + halfV;
    end else begin : g_muNeg
      assign u0 = r1Q - halfV;
    end
  endgenerate
  assign u1 = -halfV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r0Q <= '0;
      r1Q <= '0;
    end else if (ctl.load) begin
      r0Q <= {{(R_W-IN_W){pairR0[IN_W-1]}}, pairR0};
      r1Q <= {{(R_W-IN_W){pairR1[IN_W-1]}}, pairR1};
    end else if (ctl.step) begin
      r0Q <= u0;
      r1Q <= u1;
    end
  end

  assign pairZero = (r0Q == '0) && (r1Q == '0);

  // group assembly
  logic [W-1:0]     grpQ;
  logic [POS_W-1:0] posQ;
  logic [A_W-1:0]   grpIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpQ    <= '0;
      posQ    <= '0;
      grpIdxQ <= '0;
    end else if (ctl.load) begin
      grpQ    <= '0;
      posQ    <= '0;
      grpIdxQ <= '0;
    end else if (ctl.flushGrp) begin
      grpQ    <= '0;
      posQ    <= '0;
      grpIdxQ <= grpIdxQ + 1'b1;
    end else if (ctl.step) begin
      grpQ[posQ[$clog2(W)-1:0]] <= digit;
      posQ <= posQ + 1'b1;
    end
  end

  assign posLast    = (posQ == POS_W'(W - 1));
  assign grpNonzero = |grpQ;

  // expansion table
  logic [ENT_W-1:0] tblMem [TBL_N];

  always_ff @(posedge clk) begin
    if (tblWe) tblMem[tblAddr] <= tblData;
  end

  logic [ENT_W-1:0] entry;
  logic [CNT_W-1:0] rawCnt, effCnt, slotQ;
  logic [TW-1:0]    curTerm;
  logic [LA_W-1:0]  localA;

  assign entry   = tblMem[grpQ];
  assign rawCnt  = entry[ENT_W-1 -: CNT_W];
  assign effCnt  = (rawCnt > CNT_W'(MAXT)) ? CNT_W'(MAXT) : rawCnt;
  assign curTerm = entry[int'(slotQ) * TW +: TW];

  assign entryEmpty = (effCnt == '0);
  assign lastTerm   = (slotQ == effCnt - 1'b1);

  assign termNeg = curTerm[TW-1];
  assign localA  = curTerm[TW-2 -: LA_W];
  assign termB   = curTerm[B_W-1:0];
  assign termA   = grpIdxQ * A_W'(W) + A_W'(localA);

  // slot pointer and statistics
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ     <= '0;
      maxB      <= '0;
      termTotal <= '0;
    end else if (ctl.load) begin
      slotQ     <= '0;
      maxB      <= '0;
      termTotal <= '0;
    end else begin
      if (ctl.flushGrp)      slotQ <= '0;
      else if (ctl.takeTerm) slotQ <= slotQ + 1'b1;
      if (ctl.takeTerm) begin
        termTotal <= termTotal + 1'b1;
        if (termB > maxB) maxB <= termB;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (u0[R_W-1] == u0[R_W-2]) && (u1[R_W-1] == u1[R_W-2])); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> posQ < POS_W'(W)); // R4
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeTerm && !ctl.load |=> termTotal == $past(termTotal) + 1'b1); // R8
  AST_MAXB_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeTerm && !ctl.load |=> maxB >= $past(termB)); // R8
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> termTotal == '0 && maxB == '0 && grpIdxQ == '0); // R8

endmodule

// File: rtl/tau_block_recoder.sv
module tau_block_recoder
  import tbr_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int W     = 7,
  parameter int MAXT  = 4,
  parameter int LA_W  = 4,
  parameter int B_W   = 4,
  parameter int A_W   = 8,
  parameter int D_W   = 8,
  parameter int MU    = 1,
  localparam int ENT_W = $clog2(MAXT + 1) + MAXT * (1 + LA_W + B_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IN_W-1:0]  pairR0,
  input  logic [IN_W-1:0]  pairR1,
  output logic             busy,
  output logic             done,
  output logic             termValid,
  input  logic             termReady,
  output logic             termNeg,
  output logic [A_W-1:0]   termA,
  output logic [B_W-1:0]   termB,
  output logic [B_W-1:0]   maxB,
  output logic [D_W-1:0]   termTotal,
  input  logic             tblWe,
  input  logic [W-1:0]     tblAddr,
  input  logic [ENT_W-1:0] tblData
);

  tbrCtl_s ctl;
  logic    pairZero, posLast, grpNonzero, entryEmpty, lastTerm;

  tbr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .termReady  (termReady),
    .pairZero   (pairZero),
    .posLast    (posLast),
    .grpNonzero (grpNonzero),
    .entryEmpty (entryEmpty),
    .lastTerm   (lastTerm),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .termValid  (termValid)
  );

  tbr_datapath #(
    .IN_W (IN_W),
    .W    (W),
    .MAXT (MAXT),
    .LA_W (LA_W),
    .B_W  (B_W),
    .A_W  (A_W),
    .D_W  (D_W),
    .MU   (MU)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .pairR0     (pairR0),
    .pairR1     (pairR1),
    .tblWe      (tblWe),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .pairZero   (pairZero),
    .posLast    (posLast),
    .grpNonzero (grpNonzero),
    .entryEmpty (entryEmpty),
    .lastTerm   (lastTerm),
    .termNeg    (termNeg),
    .termA      (termA),
    .termB      (termB),
    .maxB       (maxB),
    .termTotal  (termTotal)
  );

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    termValid && !termReady |=> $stable(termNeg) && $stable(termA) && $stable(termB)); // R7
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && !done |=> busy); // R2

endmodule

// File: tb/tau_block_recoder_test.sv
`timescale 1ns/1ps
module tau_block_recoder_test;

  localparam int IN_W  = 16;
  localparam int W     = 7;
  localparam int MAXT  = 4;
  localparam int LA_W  = 4;
  localparam int B_W   = 4;
  localparam int A_W   = 8;
  localparam int D_W   = 8;
  localparam int TW    = 1 + LA_W + B_W;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam int ENT_W = CNT_W + MAXT * TW;

  // stimulus table: pair and ready pattern
  localparam int NV = 10;
  localparam int VR0 [NV] = '{-104, 0, 1, -1, 100, 5, -3000, 32767, -32768, 6};
  localparam int VR1 [NV] = '{  50, 0, 0,  0, -33, 9,  1234, -32768, 32767, -17};
  localparam int VMD [NV] = '{   0, 0, 1,  2,   1, 2,     0,      1,     2,   0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IN_W-1:0] pairR0 = '0, pairR1 = '0;
  logic busy, done, termValid, termNeg;
  logic termReady = 1'b0;
  logic [A_W-1:0] termA;
  logic [B_W-1:0] termB, maxB;
  logic [D_W-1:0] termTotal;
  logic tblWe = 1'b0;
  logic [W-1:0] tblAddr = '0;
  logic [ENT_W-1:0] tblData = '0;

  always #2.5 clk = ~clk;

  tau_block_recoder #(
    .IN_W(IN_W), .W(W), .MAXT(MAXT), .LA_W(LA_W), .B_W(B_W),
    .A_W(A_W), .D_W(D_W), .MU(1)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .pairR0(pairR0), .pairR1(pairR1),
    .busy(busy), .done(done), .termValid(termValid), .termReady(termReady),
    .termNeg(termNeg), .termA(termA), .termB(termB), .maxB(maxB),
    .termTotal(termTotal), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData)
  );

  int total = 0;
  int bad = 0;

  int expN, expMax;
  int expS [64];
  int expA [64];
  int expB [64];
  int gotN;
  int gotS [64];
  int gotA [64];
  int gotB [64];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // table contents chosen by the bench (R11 layout)
  function automatic logic [ENT_W-1:0] tbl_entry(input int v);
    logic [ENT_W-1:0] e;
    int n;
    e = '0;
    n = 0;
    if (v == 36) begin
      e[0 +: TW] = {1'b0, 4'd2, 4'd2};
      e[ENT_W-1 -: CNT_W] = CNT_W'(1);
    end else if (v == 116) begin
      e[0 +: TW]  = {1'b0, 4'd1, 4'd1};
      e[TW +: TW] = {1'b0, 4'd1, 4'd6};
      e[ENT_W-1 -: CNT_W] = CNT_W'(2);
    end else begin
      for (int p = 0; p < W; p++) begin
        if (((v >> p) & 1) == 1 && n < MAXT) begin
          e[n*TW +: TW] = {1'(p & 1), 4'(p), 4'((v + p) % 16)};
          n++;
        end
      end
      e[ENT_W-1 -: CNT_W] = CNT_W'(n);
    end
    return e;
  endfunction

  task automatic add_group(input int v, input int g);
    logic [ENT_W-1:0] e;
    logic [TW-1:0] t;
    int c;
    e = tbl_entry(v);
    c = int'(e[ENT_W-1 -: CNT_W]);
    for (int j = 0; j < c; j++) begin
      t = e[j*TW +: TW];
      expS[expN] = int'(t[TW-1]);
      expA[expN] = g * W + int'(t[TW-2 -: LA_W]);
      expB[expN] = int'(t[B_W-1:0]);
      if (expB[expN] > expMax) expMax = expB[expN];
      expN++;
    end
  endtask

  // digit model from R3/R4 with mu = +1
  task automatic build_expect(input longint x0, input longint x1);
    longint p0, p1, h, n0;
    int pos, v, g, d;
    p0 = x0; p1 = x1; pos = 0; v = 0; g = 0;
    expN = 0; expMax = 0;
    while (p0 != 0 || p1 != 0) begin
      d = (p0 % 2 != 0) ? 1 : 0;
      p0 = p0 - d;
      h = p0 / 2;
      n0 = p1 + h;
      p1 = -h;
      p0 = n0;
      v = v | (d << pos);
      pos++;
      if (pos == W) begin
        if (v != 0) add_group(v, g);
        v = 0; pos = 0; g++;
      end
    end
    if (v != 0) add_group(v, g);
  endtask

  function automatic bit ready_pat(input int mode, input int c);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (c % 2) == 0;
    return (c % 3) == 2;
  endfunction

  task automatic run_vec(input int r0, input int r1, input int mode, input bit inject);
    int cyc;
    bit fin, pv, pr;
    logic [A_W+B_W:0] pp;
    int holdBad;
    build_expect(r0, r1);
    gotN = 0; holdBad = 0; pv = 0; pr = 0; pp = '0; fin = 0; cyc = 0;
    @(negedge clk);
    pairR0 = IN_W'(r0); pairR1 = IN_W'(r1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    while (!fin && cyc < 4000) begin
      if (pv && !pr) begin
        if (!termValid || {termNeg, termA, termB} != pp) holdBad++;
      end
      if (done) begin
        fin = 1;
      end else begin
        termReady = ready_pat(mode, cyc);
        if (inject && cyc == 2) begin
          start = 1'b1; pairR0 = IN_W'(555); pairR1 = IN_W'(3);
        end else if (inject && cyc == 3) begin
          start = 1'b0; pairR0 = IN_W'(r0); pairR1 = IN_W'(r1);
        end
        if (termValid && termReady && gotN < 64) begin
          gotS[gotN] = int'(termNeg);
          gotA[gotN] = int'(termA);
          gotB[gotN] = int'(termB);
          gotN++;
        end
        pv = termValid; pr = termReady; pp = {termNeg, termA, termB};
        @(negedge clk);
        cyc++;
      end
    end
    termReady = 1'b0;
    start = 1'b0;
    check(fin, "R9 done reached", fin, 1);
    check(holdBad == 0, "R7 held term stable", holdBad, 0);
    check(gotN == expN, "R5 R6 term count", gotN, expN);
    check(int'(termTotal) == expN, "R8 termTotal", termTotal, expN);
    check(int'(maxB) == expMax, "R8 maxB", maxB, expMax);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotS[i] == expS[i], "R11 term sign", gotS[i], expS[i]);
      check(gotA[i] == expA[i], "R4 R6 term a", gotA[i], expA[i]);
      check(gotB[i] == expB[i], "R3 term b", gotB[i], expB[i]);
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done one cycle, idle after", {done, busy}, 0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy at reset", busy, 0);
    check(done == 1'b0, "R1 done at reset", done, 0);
    check(termValid == 1'b0, "R1 termValid at reset", termValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(termTotal == '0, "R1 termTotal at reset", termTotal, 0);
    check(maxB == '0, "R1 maxB at reset", maxB, 0);

    // R11 table load while idle
    for (int v = 0; v < (1 << W); v++) begin
      tblWe = 1'b1; tblAddr = W'(v); tblData = tbl_entry(v);
      @(negedge clk);
    end
    tblWe = 1'b0;

    // table-driven vectors; vector 0 also pulses start mid-run (R2)
    for (int i = 0; i < NV; i++) begin
      run_vec(VR0[i], VR1[i], VMD[i], i == 0);
    end

    // R10 worked case, compared with literal values
    run_vec(-104, 50, 1, 1'b0);
    check(gotN == 3, "R10 term count", gotN, 3);
    check(gotN == 3 && gotA[0] == 2 && gotB[0] == 2 && gotS[0] == 0, "R10 term0", gotA[0], 2);
    check(gotN == 3 && gotA[1] == 8 && gotB[1] == 1 && gotS[1] == 0, "R10 term1", gotA[1], 8);
    check(gotN == 3 && gotA[2] == 8 && gotB[2] == 6 && gotS[2] == 0, "R10 term2", gotA[2], 8);
    check(int'(maxB) == 6, "R10 maxB", maxB, 6);

    // R5 tau^9: empty group 0, one term from group 1 (entry 4 -> a=2,b=6)
    run_vec(6, -17, 0, 1'b0);
    check(gotN == 1 && gotA[0] == 9 && gotB[0] == 6, "R5 single term after empty group", gotA[0], 9);

    // R5 zero input: no terms
    run_vec(0, 0, 0, 1'b0);
    check(gotN == 0 && termTotal == '0, "R5 zero input no terms", gotN, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule